// File: doc/BRIEF.md
# Pairwise floating-point maximum-number reducer

This block takes one packed pair of IEEE-754 binary values and returns the larger of the two as a scalar. It handles half, single and double precision, picked by a two-bit format input. The operand word is always twice the element width. Element A sits in the low half of that word and element B sits directly above it.

The comparison follows maxNum rules. A quiet NaN loses to any number, and negative zero ranks strictly below positive zero. A signaling NaN, or two NaNs at once, produces a NaN result. A control bit decides what that NaN is. With the bit low, one of the input NaNs is quieted and passed on. With the bit high, the canonical default NaN is emitted. An invalid-operation flag goes with the result. The result and flag are registered, so they appear one cycle after the input strobe, together with an output strobe.

Top module: `fp_pair_maxnum`

## Requirements
- R1: `in_fmt` 2'b00 selects half (16-bit elements) and 2'b01 selects single (32-bit). 2'b10 and 2'b11 both select double (64-bit). Element A is `in_pair[EW-1:0]` and element B is `in_pair[2*EW-1:EW]`. Bits of `in_pair` above 2*EW are ignored. The result occupies `out_res[EW-1:0]`, and the bits above it read zero.
- R2: `out_vld` equals the `in_vld` of the previous clock. When `out_vld` is high, `out_res` and `out_inv` belong to the operands sampled at that edge. Back-to-back operations are accepted on every cycle.
- R3: When neither element is a NaN, the result is the larger value under sign-magnitude ordering. This covers infinities and subnormals, and subnormals are not flushed. Equal elements return A.
- R4: Negative zero is less than positive zero, so a pair of +0 and -0 returns +0 in either order.
- R5: When exactly one element is a quiet NaN (exponent all ones, fraction MSB set) and the other is a number, the result is the number.
- R6: If either element is a signaling NaN (exponent all ones, fraction MSB clear, fraction nonzero), or both are NaNs, and `in_dn` is 0, the result is an input NaN with its fraction MSB forced to 1. Sign and payload are kept. The NaN is chosen in this order: signaling A, signaling B, quiet A, quiet B.
- R7: `out_inv` is 1 exactly when at least one element is a signaling NaN. Quiet NaNs alone leave it at 0.
- R8: Under the NaN conditions of R6 with `in_dn` at 1, the result is the default NaN: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000.
- R9: After reset, `out_vld`, `out_res` and `out_inv` are 0. While `in_vld` is low, `out_res` and `out_inv` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| in_fmt | input | 2 | Element format select |
| in_dn | input | 1 | 1: emit default NaN; 0: propagate quieted NaN |
| in_pair | input | 128 | Packed pair, A low, B high |
| out_vld | output | 1 | Result strobe |
| out_res | output | 64 | Scalar result, zero-extended |
| out_inv | output | 1 | Invalid-operation flag |

## Verification
The assertions compare the output word with the format that was applied one cycle earlier. They therefore assume `in_fmt` is driven to a known value on every cycle that `in_vld` is high. They also assume reset is applied before the first strobe. The bench keeps to this by changing `in_fmt`, `in_dn` and `in_pair` only on falling edges and only together with a defined strobe. It leaves them at their last legal value while the strobe is low.

// File: rtl/fpmx_pkg.sv
package fpmx_pkg;

    localparam int MAX_EW  = 64;
    localparam int NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_DBLALT = 2'b11
    } fmt_e;

    // exponent field width for an IEEE-754 binary element
    function automatic int exp_width(input int ew);
        if (ew == 16) return 5;
        if (ew == 32) return 8;
        return 11;
    endfunction

    typedef struct packed {
        logic              vld;
        logic              inv;
        logic [MAX_EW-1:0] res;
    } out_st_t;

endpackage

// File: rtl/fpmx_class.sv
module fpmx_class #(
    parameter int EW = 32
) (
    input  logic [EW-1:0] elem,
    output logic          is_nan,
    output logic          is_snan
);
    localparam int EXW = fpmx_pkg::exp_width(EW);
    localparam int FW  = EW - 1 - EXW;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &elem[EW-2:FW];
        frac_nz  = |elem[FW-1:0];
        is_nan   = exp_ones && frac_nz;
        is_snan  = is_nan && !elem[FW-1];
    end

endmodule

// File: rtl/fpmx_lane.sv
module fpmx_lane #(
    parameter int EW = 32
) (
    input  logic [2*EW-1:0] pair,
    input  logic            dn,
    output logic [EW-1:0]   res,
    output logic            inv
);
    localparam int EXW = fpmx_pkg::exp_width(EW);
    localparam int FW  = EW - 1 - EXW;
    localparam logic [EW-1:0] QBIT = EW'(1) << (FW - 1);
    localparam logic [EW-1:0] DNAN = {1'b0, {EXW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic [EW-1:0] a_w, b_w;
    logic          a_nan, a_snan, b_nan, b_snan;
    logic          b_wins;
    logic          nan_out;
    logic [EW-1:0] nan_pick;

    assign a_w = pair[EW-1:0];
    assign b_w = pair[2*EW-1:EW];

    fpmx_class #(.EW(EW)) u_class_a (.elem(a_w), .is_nan(a_nan), .is_snan(a_snan));
    fpmx_class #(.EW(EW)) u_class_b (.elem(b_w), .is_nan(b_nan), .is_snan(b_snan));

    always_comb begin
        // sign-magnitude ordering; ties keep A
        if (a_w[EW-1] != b_w[EW-1]) begin
            b_wins = a_w[EW-1];
        end else if (a_w[EW-1]) begin
            b_wins = b_w[EW-2:0] < a_w[EW-2:0];
        end else begin
            b_wins = b_w[EW-2:0] > a_w[EW-2:0];
        end

        nan_out = a_snan || b_snan || (a_nan && b_nan);

        if (a_snan)      nan_pick = a_w;
        else if (b_snan) nan_pick = b_w;
        else if (a_nan)  nan_pick = a_w;
        else             nan_pick = b_w;

        if (nan_out)     res = dn ? DNAN : (nan_pick | QBIT);
        else if (a_nan)  res = b_w;
        else if (b_nan)  res = a_w;
        else if (b_wins) res = b_w;
        else             res = a_w;

        inv = a_snan || b_snan;
    end

endmodule

// File: rtl/fp_pair_maxnum.sv
module fp_pair_maxnum
    import fpmx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [1:0]            in_fmt,
    input  logic                  in_dn,
    input  logic [2*MAX_EW-1:0]   in_pair,
    output logic                  out_vld,
    output logic [MAX_EW-1:0]     out_res,
    output logic                  out_inv
);
    logic [MAX_EW-1:0] lane_res [NUM_FMT];
    logic              lane_inv [NUM_FMT];

    for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_lane
        localparam int EW = 16 << gi;
        logic [EW-1:0] r_w;
        fpmx_lane #(.EW(EW)) u_lane (
            .pair (in_pair[2*EW-1:0]),
            .dn   (in_dn),
            .res  (r_w),
            .inv  (lane_inv[gi])
        );
        assign lane_res[gi] = MAX_EW'(r_w);
    end

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            case (fmt_e'(in_fmt))
                FMT_HALF:   begin st_d.res = lane_res[0]; st_d.inv = lane_inv[0]; end
                FMT_SINGLE: begin st_d.res = lane_res[1]; st_d.inv = lane_inv[1]; end
                default:    begin st_d.res = lane_res[2]; st_d.inv = lane_inv[2]; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_res = st_q.res;
    assign out_inv = st_q.inv;

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_res) && $stable(out_inv)));
    a_r1_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(in_fmt) == 2'b00) |-> (out_res[63:16] == '0));
    a_r1_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(in_fmt) == 2'b01) |-> (out_res[63:32] == '0));
    a_r7_half_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_inv && $past(in_fmt) == 2'b00) |-> (&out_res[14:10] && out_res[9]));
    a_r7_single_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_inv && $past(in_fmt) == 2'b01) |-> (&out_res[30:23] && out_res[22]));
    a_r7_double_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_inv && $past(in_fmt[1])) |-> (&out_res[62:52] && out_res[51]));

endmodule

// File: tb/test_fp_pair_maxnum.sv
module test_fp_pair_maxnum;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [1:0]   in_fmt = 2'b00;
    logic         in_dn = 1'b0;
    logic [127:0] in_pair = '0;
    logic         out_vld;
    logic [63:0]  out_res;
    logic         out_inv;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    fp_pair_maxnum i_fp_pair_maxnum (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fmt(in_fmt),
        .in_dn(in_dn), .in_pair(in_pair),
        .out_vld(out_vld), .out_res(out_res), .out_inv(out_inv)
    );

    typedef struct packed {
        logic [15:0]  tag;
        logic [1:0]   fmt;
        logic         dn;
        logic [127:0] op;   // {B, A}
        logic [63:0]  res;
        logic         inv;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{"R3", 2'd0, 1'b0, {96'h0, 16'h4000, 16'h3C00}, 64'h4000, 1'b0},
        '{"R3", 2'd0, 1'b0, {96'h0, 16'hC000, 16'hBC00}, 64'hBC00, 1'b0},
        '{"R4", 2'd0, 1'b0, {96'h0, 16'h0000, 16'h8000}, 64'h0000, 1'b0},
        '{"R4", 2'd0, 1'b0, {96'h0, 16'h8000, 16'h0000}, 64'h0000, 1'b0},
        '{"R5", 2'd0, 1'b0, {96'h0, 16'h3C00, 16'h7E05}, 64'h3C00, 1'b0},
        '{"R6", 2'd0, 1'b0, {96'h0, 16'h7E77, 16'h7E05}, 64'h7E05, 1'b0},
        '{"R6", 2'd0, 1'b0, {96'h0, 16'h7C01, 16'h7E05}, 64'h7E01, 1'b1},
        '{"R6", 2'd0, 1'b0, {96'h0, 16'h3C00, 16'hFC01}, 64'hFE01, 1'b1},
        '{"R8", 2'd0, 1'b1, {96'h0, 16'h3C00, 16'h7C01}, 64'h7E00, 1'b1},
        '{"R1", 2'd0, 1'b0, {{96{1'b1}}, 16'h4000, 16'h3C00}, 64'h4000, 1'b0},
        '{"R3", 2'd1, 1'b0, {64'h0, 32'h7F800000, 32'h3F800000}, 64'h7F800000, 1'b0},
        '{"R3", 2'd1, 1'b0, {64'h0, 32'h00000003, 32'h00000001}, 64'h00000003, 1'b0},
        '{"R4", 2'd1, 1'b0, {64'h0, 32'h00000000, 32'h80000000}, 64'h00000000, 1'b0},
        '{"R5", 2'd1, 1'b0, {64'h0, 32'h7FC00001, 32'hC0000000}, 64'hC0000000, 1'b0},
        '{"R6", 2'd1, 1'b0, {64'h0, 32'h7F800009, 32'h7F800005}, 64'h7FC00005, 1'b1},
        '{"R8", 2'd1, 1'b1, {64'h0, 32'hFFC00000, 32'h7FC12345}, 64'h7FC00000, 1'b0},
        '{"R7", 2'd1, 1'b0, {64'h0, 32'h3F800000, 32'h7F800001}, 64'h7FC00001, 1'b1},
        '{"R7", 2'd1, 1'b0, {64'h0, 32'h7FC00000, 32'h7FC00007}, 64'h7FC00007, 1'b0},
        '{"R3", 2'd2, 1'b0, {64'hFFF0000000000000, 64'hBFF0000000000000}, 64'hBFF0000000000000, 1'b0},
        '{"R4", 2'd2, 1'b0, {64'h0000000000000000, 64'h8000000000000000}, 64'h0000000000000000, 1'b0},
        '{"R6", 2'd2, 1'b0, {64'h7FF8000000000002, 64'h7FF0000000000001}, 64'h7FF8000000000001, 1'b1},
        '{"R8", 2'd2, 1'b1, {64'h3FF0000000000000, 64'h7FF4000000000000}, 64'h7FF8000000000000, 1'b1},
        '{"R1", 2'd3, 1'b0, {64'h3FF0000000000000, 64'h4000000000000000}, 64'h4000000000000000, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "reset vld", {63'h0, out_vld}, 64'h0);
        check("R9", "reset res", out_res, 64'h0);
        check("R9", "reset inv", {63'h0, out_inv}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_vld  = 1'b1;
            in_fmt  = VECS[i].fmt;
            in_dn   = VECS[i].dn;
            in_pair = VECS[i].op;
            @(negedge clk);
            in_vld = 1'b0;
            check("R2", "vld", {63'h0, out_vld}, 64'h1);
            check(string'(VECS[i].tag), "res", out_res, VECS[i].res);
            check("R7", "inv", {63'h0, out_inv}, {63'h0, VECS[i].inv});
            @(negedge clk);
        end

        // R9 hold while idle, new operands present but not strobed
        held    = out_res;
        in_fmt  = 2'b00;
        in_pair = {96'h0, 16'h7C01, 16'h3C00};
        repeat (2) @(negedge clk);
        check("R9", "idle vld", {63'h0, out_vld}, 64'h0);
        check("R9", "idle res", out_res, held);
        check("R9", "idle inv", {63'h0, out_inv}, 64'h0);

        // R2 back-to-back strobes
        in_vld = 1'b1; in_fmt = 2'b00; in_dn = 1'b0;
        in_pair = {96'h0, 16'h4400, 16'h4200};
        @(negedge clk);
        check("R2", "b2b first", out_res, 64'h4400);
        in_fmt = 2'b01;
        in_pair = {64'h0, 32'hBF800000, 32'h80000000};
        @(negedge clk);
        check("R2", "b2b second", out_res, 64'h80000000);
        check("R2", "b2b vld", {63'h0, out_vld}, 64'h1);
        in_vld = 1'b0;
        @(negedge clk);
        check("R2", "b2b drop", {63'h0, out_vld}, 64'h0);

        done = 1'b1;
        finish_run();
    end

endmodule